// File: doc/BRIEF.md
# Word-Granular Write Mask Tracker

This unit sits beside a private first-level data cache and records which 4-byte words of each cached line this core has changed. With that record, a later write-back carries only those words, so two cores that write different words of the same line never overwrite each other's data.

Aligned stores of whole words made outside a critical section are tracked. The unit ORs the covered word bits into a per-line mask held in a small set-associative mask cache. Every other store goes to the next level as a write-through request: stores of one to three bytes, misaligned stores, stores that cross a line, and any store made while the critical-section flag is set.

A line eviction, a mask-cache replacement or a flush turns a mask entry into one write-back request. The request carries the line address and the word mask. All requests leave through a single valid/ready port.

Top module: `write_mask_tracker`

## Requirements
- R1: A store is tracked when all of these hold: the critical flag is low, the size is a nonzero multiple of 4 bytes, the address is word aligned, and all covered words lie inside one 32-byte line. A tracked store raises no request of its own, except a replacement write-back under R7.
- R2: A store of 1, 2 or 3 bytes raises a write-through request on the cycle after acceptance. The request has reqWriteBack=0, reqAddr equal to the store address and reqSize equal to the store size. It sets no mask bit.
- R3: A store accepted with stCrit=1 raises a write-through request and sets no mask bit, whatever its size.
- R4: A word-sized store that is misaligned, or that runs past the end of its line, is sent as write-through and sets no mask bit.
- R5: Mask bit i stands for the word at address bits [4:2] = i. Tracked stores to the same line accumulate by OR.
- R6: An accepted line eviction (evLine = address bits [31:5]) whose line has an entry raises one write-back request on the next cycle. The request has reqWriteBack=1, the line base address and the mask, and the entry is removed. A line with no entry raises nothing.
- R7: The mask cache has 8 entries in 2 sets, chosen by address bit 5, with 4 ways each. A miss takes the lowest-numbered free way. When the set is full, the miss takes the least recently used way and writes that way's line back on the cycle after the store is accepted.
- R8: A flush pulse scans the entries in the order set 0 ways 0 to 3, then set 1 ways 0 to 3. It raises one write-back per valid entry and clears each one. Stores and evictions stall during the scan.
- R9: A pending request holds all of its fields stable until reqReady is seen. While it is pending, stReady and evReady are low.
- R10: When a tracked store and the eviction of the same line are accepted in one cycle, the store is applied first. The write-back mask therefore includes the store's words, and no entry remains for the line.
- R11: After reset no entry is valid, reqValid is low, and stReady and evReady are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Store request valid |
| stReady | output | 1 | Store accepted this cycle when high with stValid |
| stAddr | input | 32 | Store byte address |
| stSize | input | 6 | Store size in bytes, 1 to 32 |
| stCrit | input | 1 | Store issued inside a critical section |
| evValid | input | 1 | First-level cache evicts a line |
| evReady | output | 1 | Eviction accepted this cycle when high with evValid |
| evLine | input | 27 | Line address (byte address bits 31:5) of the eviction |
| flushReq | input | 1 | Pulse: write back and clear every mask entry |
| reqValid | output | 1 | Outgoing request valid |
| reqReady | input | 1 | Next level takes the request |
| reqWriteBack | output | 1 | 1 = masked write-back, 0 = write-through |
| reqAddr | output | 32 | Line base (write-back) or store address (write-through) |
| reqMask | output | 8 | Dirty-word mask of a write-back, zero otherwise |
| reqSize | output | 6 | Byte count of a write-through, zero otherwise |

## Verification
Every request is registered, so a store or eviction accepted on one rising edge shows its request at the falling edge that follows. The bench drives inputs on a falling edge and reads the request one full cycle later at the next falling edge, never at the rising edge itself. Mask contents are only visible through write-backs, so each tracked store is followed by an eviction of its line, and that write-back is read one cycle after the eviction is accepted. During a flush scan the write-backs arrive one every two cycles while the port is freed. For these the bench waits a bounded number of falling edges for each request and then checks its order and contents.

// File: rtl/wmt_pkg.sv
package wmt_pkg;

  // strobes from control to datapath, one per state change
  typedef struct packed {
    logic stThrough;   // forward the store as write-through
    logic stUpdate;    // OR store words into the hit entry
    logic stAlloc;     // allocate an entry for the store
    logic evKill;      // emit write-back for evicted line, drop entry
    logic evWithStore; // store to the same line merges into that write-back
    logic flushKill;   // emit write-back for the scanned entry, drop it
  } wmtStrobes_t;

  typedef enum logic {
    FL_IDLE = 1'b0,
    FL_SCAN = 1'b1
  } wmtFlush_t;

endpackage

// File: rtl/wmt_ctrl.sv
module wmt_ctrl
  import wmt_pkg::*;
#(
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  parameter int ENTRIES    = 8,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int WB_W   = $clog2(WORD_BYTES),
  localparam int SIZE_W = OFF_W + 1,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stValid,
  input  logic [OFF_W-1:0]  stOffset,
  input  logic [SIZE_W-1:0] stSize,
  input  logic              stCrit,
  input  logic              evValid,
  input  logic              flushReq,
  input  logic              stHit,
  input  logic              stSetFull,
  input  logic              sameLine,
  input  logic              evHit,
  input  logic              scanEntValid,
  input  logic              outValid,
  output logic              stReady,
  output logic              evReady,
  output logic [IDX_W-1:0]  scanIdx,
  output wmtStrobes_t       str
);

  localparam int WORDS = LINE_BYTES / WORD_BYTES;
  localparam logic [SIZE_W-1:0] WORD_SZ = SIZE_W'(WORD_BYTES);
  localparam logic [SIZE_W-1:0] LINE_SZ = SIZE_W'(LINE_BYTES);
  localparam logic [SIZE_W:0]   WORDS_X = (SIZE_W+1)'(WORDS);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(ENTRIES - 1);

  wmtFlush_t   state;
  logic        tracked, sizeOk, alignOk, fitsLine;
  logic [SIZE_W:0] endWord;
  logic        portFree, stNeedPort, stAcc, evAcc, merge;

  assign endWord  = (SIZE_W+1)'(stOffset[OFF_W-1:WB_W]) + (SIZE_W+1)'(stSize >> WB_W);
  assign sizeOk   = (stSize >= WORD_SZ) && (stSize <= LINE_SZ) && (stSize[WB_W-1:0] == '0);
  assign alignOk  = (stOffset[WB_W-1:0] == '0);
  assign fitsLine = (endWord <= WORDS_X);
  assign tracked  = !stCrit && sizeOk && alignOk && fitsLine;

  assign portFree   = !outValid && (state == FL_IDLE);
  assign stNeedPort = stValid && (!tracked || (!stHit && stSetFull));
  assign stReady    = portFree;
  assign evReady    = portFree && !stNeedPort;
  assign stAcc      = stValid && stReady;
  assign evAcc      = evValid && evReady;
  assign merge      = stAcc && tracked && evAcc && sameLine;

  always_comb begin
    str             = '0;
    str.stThrough   = stAcc && !tracked;
    str.stUpdate    = stAcc && tracked && stHit && !merge;
    str.stAlloc     = stAcc && tracked && !stHit && !merge;
    str.evKill      = evAcc && (evHit || merge);
    str.evWithStore = merge;
    str.flushKill   = (state == FL_SCAN) && !outValid && scanEntValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= FL_IDLE;
      scanIdx <= '0;
    end else begin
      case (state)
        FL_IDLE: if (flushReq) begin
          state   <= FL_SCAN;
          scanIdx <= '0;
        end
        FL_SCAN: if (!outValid) begin
          if (scanIdx == LAST_IDX) state <= FL_IDLE;
          else scanIdx <= scanIdx + 1'b1;
        end
        default: state <= FL_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wmt_datapath.sv
module wmt_datapath
  import wmt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  parameter int SETS       = 2,
  parameter int WAYS       = 4,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int WB_W    = $clog2(WORD_BYTES),
  localparam int SIZE_W  = OFF_W + 1,
  localparam int WORDS   = LINE_BYTES / WORD_BYTES,
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int ENTRIES = SETS * WAYS,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int LINE_W  = ADDR_W - OFF_W,
  localparam int TAG_W   = LINE_W - SET_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  wmtStrobes_t       str,
  input  logic [IDX_W-1:0]  scanIdx,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [SIZE_W-1:0] stSize,
  input  logic [LINE_W-1:0] evLine,
  input  logic              reqReady,
  output logic              stHit,
  output logic              stSetFull,
  output logic              sameLine,
  output logic              evHit,
  output logic              scanEntValid,
  output logic              outValid,
  output logic              outWb,
  output logic [ADDR_W-1:0] outAddr,
  output logic [WORDS-1:0]  outMask,
  output logic [SIZE_W-1:0] outSize
);

  logic [ENTRIES-1:0] entValid;
  logic [TAG_W-1:0]   entTag  [ENTRIES];
  logic [WORDS-1:0]   entMask [ENTRIES];
  logic [WAY_W-1:0]   entAge  [ENTRIES];
  logic [WAY_W-1:0]   ageNext [ENTRIES];

  logic [SET_W-1:0] stSet, evSet;
  logic [TAG_W-1:0] stTag, evTag;
  logic [WAYS-1:0]  stHitVec, evHitVec, stFreeVec, stOldVec;
  logic [WAY_W-1:0] stHitWay, evHitWay, freeWay, lruWay, allocWay, touchWay;
  logic [IDX_W-1:0] stHitIdx, evHitIdx, allocIdx;
  logic [WAY_W-1:0] touchAge;
  logic             touch;
  logic [WORDS-1:0] stBits;
  logic [OFF_W-WB_W-1:0]   stWord;
  logic [SIZE_W-WB_W-1:0]  stCount;

  assign stSet   = stAddr[OFF_W +: SET_W];
  assign stTag   = stAddr[ADDR_W-1 -: TAG_W];
  assign evSet   = evLine[SET_W-1:0];
  assign evTag   = evLine[LINE_W-1:SET_W];
  assign sameLine = (stAddr[ADDR_W-1:OFF_W] == evLine);
  assign stWord  = stAddr[OFF_W-1:WB_W];
  assign stCount = stSize[SIZE_W-1:WB_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic [WAY_W-1:0] WID = WAY_W'(w);
    assign stHitVec[w]  = entValid[{stSet, WID}] && (entTag[{stSet, WID}] == stTag);
    assign evHitVec[w]  = entValid[{evSet, WID}] && (entTag[{evSet, WID}] == evTag);
    assign stFreeVec[w] = !entValid[{stSet, WID}];
    assign stOldVec[w]  = (entAge[{stSet, WID}] == WAY_W'(WAYS - 1));
  end

  // lowest index wins for every encoder
  always_comb begin
    stHitWay = '0;
    evHitWay = '0;
    freeWay  = '0;
    lruWay   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (stHitVec[w])  stHitWay = WAY_W'(w);
      if (evHitVec[w])  evHitWay = WAY_W'(w);
      if (stFreeVec[w]) freeWay  = WAY_W'(w);
      if (stOldVec[w])  lruWay   = WAY_W'(w);
    end
  end

  assign stHit     = |stHitVec;
  assign evHit     = |evHitVec;
  assign stSetFull = !(|stFreeVec);
  assign allocWay  = stSetFull ? lruWay : freeWay;
  assign stHitIdx  = {stSet, stHitWay};
  assign evHitIdx  = {evSet, evHitWay};
  assign allocIdx  = {stSet, allocWay};
  assign scanEntValid = entValid[scanIdx];

  always_comb begin
    stBits = '0;
    for (int i = 0; i < WORDS; i++)
      if (i >= int'(stWord) && i < int'(stWord) + int'(stCount)) stBits[i] = 1'b1;
  end

  // recency ages stay a permutation within each set
  assign touch    = str.stUpdate || str.stAlloc;
  assign touchWay = str.stUpdate ? stHitWay : allocWay;
  assign touchAge = entAge[{stSet, touchWay}];

  always_comb begin
    ageNext = entAge;
    if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touchWay)
          ageNext[{stSet, WAY_W'(w)}] = '0;
        else if (entAge[{stSet, WAY_W'(w)}] < touchAge)
          ageNext[{stSet, WAY_W'(w)}] = entAge[{stSet, WAY_W'(w)}] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      outValid <= 1'b0;
      outWb    <= 1'b0;
      outAddr  <= '0;
      outMask  <= '0;
      outSize  <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        entTag[e]  <= '0;
        entMask[e] <= '0;
        entAge[e]  <= WAY_W'(e % WAYS);
      end
    end else begin
      entAge <= ageNext;
      if (outValid && reqReady) outValid <= 1'b0;

      if (str.stThrough) begin
        outValid <= 1'b1;
        outWb    <= 1'b0;
        outAddr  <= stAddr;
        outMask  <= '0;
        outSize  <= stSize;
      end

      if (str.stUpdate) entMask[stHitIdx] <= entMask[stHitIdx] | stBits;

      if (str.stAlloc) begin
        if (stSetFull) begin
          outValid <= 1'b1;
          outWb    <= 1'b1;
          outAddr  <= {entTag[allocIdx], stSet, {OFF_W{1'b0}}};
          outMask  <= entMask[allocIdx];
          outSize  <= '0;
        end
        entValid[allocIdx] <= 1'b1;
        entTag[allocIdx]   <= stTag;
        entMask[allocIdx]  <= stBits;
      end

      if (str.evKill) begin
        outValid <= 1'b1;
        outWb    <= 1'b1;
        outAddr  <= {evLine, {OFF_W{1'b0}}};
        outMask  <= (evHit ? entMask[evHitIdx] : '0) | (str.evWithStore ? stBits : '0);
        outSize  <= '0;
        if (evHit) entValid[evHitIdx] <= 1'b0;
      end

      if (str.flushKill) begin
        outValid <= 1'b1;
        outWb    <= 1'b1;
        outAddr  <= {entTag[scanIdx], scanIdx[IDX_W-1:WAY_W], {OFF_W{1'b0}}};
        outMask  <= entMask[scanIdx];
        outSize  <= '0;
        entValid[scanIdx] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/write_mask_tracker.sv
module write_mask_tracker
  import wmt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  parameter int L1_LINES   = 64,
  parameter int MASK_RATIO = 8,
  parameter int WAYS       = 4,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int SIZE_W  = OFF_W + 1,
  localparam int WORDS   = LINE_BYTES / WORD_BYTES,
  localparam int ENTRIES = L1_LINES / MASK_RATIO,
  localparam int SETS    = ENTRIES / WAYS,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int LINE_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stValid,
  output logic              stReady,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [SIZE_W-1:0] stSize,
  input  logic              stCrit,
  input  logic              evValid,
  output logic              evReady,
  input  logic [LINE_W-1:0] evLine,
  input  logic              flushReq,
  output logic              reqValid,
  input  logic              reqReady,
  output logic              reqWriteBack,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [WORDS-1:0]  reqMask,
  output logic [SIZE_W-1:0] reqSize
);

  wmtStrobes_t      str;
  logic [IDX_W-1:0] scanIdx;
  logic stHit, stSetFull, sameLine, evHit, scanEntValid;

  wmt_ctrl #(
    .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES), .ENTRIES(ENTRIES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stOffset(stAddr[OFF_W-1:0]),
    .stSize(stSize), .stCrit(stCrit), .evValid(evValid), .flushReq(flushReq),
    .stHit(stHit), .stSetFull(stSetFull), .sameLine(sameLine), .evHit(evHit),
    .scanEntValid(scanEntValid), .outValid(reqValid), .stReady(stReady),
    .evReady(evReady), .scanIdx(scanIdx), .str(str)
  );

  wmt_datapath #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES),
    .SETS(SETS), .WAYS(WAYS)
  ) i_dp (
    .clk(clk), .rstN(rstN), .str(str), .scanIdx(scanIdx), .stAddr(stAddr),
    .stSize(stSize), .evLine(evLine), .reqReady(reqReady), .stHit(stHit),
    .stSetFull(stSetFull), .sameLine(sameLine), .evHit(evHit),
    .scanEntValid(scanEntValid), .outValid(reqValid), .outWb(reqWriteBack),
    .outAddr(reqAddr), .outMask(reqMask), .outSize(reqSize)
  );

endmodule

// File: rtl/wmt_checker.sv
module wmt_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int SIZE_W = OFF_W + 1,
  localparam int WORDS  = LINE_BYTES / WORD_BYTES
) (
  input logic              clk,
  input logic              rstN,
  input logic              stValid,
  input logic              stReady,
  input logic [ADDR_W-1:0] stAddr,
  input logic [SIZE_W-1:0] stSize,
  input logic              stCrit,
  input logic              evReady,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWriteBack,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [WORDS-1:0]  reqMask,
  input logic [SIZE_W-1:0] reqSize
);

  localparam logic [SIZE_W-1:0] WORD_SZ = SIZE_W'(WORD_BYTES);

  assert_reset_idle_R11: assert property (@(posedge clk) !rstN |=> !reqValid);

  assert_hold_pending_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr) && $stable(reqMask)
                              && $stable(reqWriteBack) && $stable(reqSize));

  assert_stall_inputs_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !stReady && !evReady);

  assert_subword_through_R2: assert property (@(posedge clk) disable iff (!rstN)
    stValid && stReady && (stSize < WORD_SZ) |=>
      reqValid && !reqWriteBack && reqSize == $past(stSize) && reqAddr == $past(stAddr));

  assert_crit_through_R3: assert property (@(posedge clk) disable iff (!rstN)
    stValid && stReady && stCrit |=> reqValid && !reqWriteBack);

  assert_wb_shape_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqWriteBack |-> reqMask != '0 && reqAddr[OFF_W-1:0] == '0);

endmodule

bind write_mask_tracker wmt_checker #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)
) i_chk (.*);

// File: tb/test_write_mask_tracker.sv
`timescale 1ns/1ps
module test_write_mask_tracker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stValid = 1'b0, stCrit = 1'b0, evValid = 1'b0, flushReq = 1'b0;
  logic        reqReady = 1'b0;
  logic [31:0] stAddr = '0;
  logic [5:0]  stSize = '0;
  logic [26:0] evLine = '0;
  logic        stReady, evReady, reqValid, reqWriteBack;
  logic [31:0] reqAddr;
  logic [7:0]  reqMask;
  logic [5:0]  reqSize;

  int nTests = 0, nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  write_mask_tracker i_write_mask_tracker (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady), .stAddr(stAddr),
    .stSize(stSize), .stCrit(stCrit), .evValid(evValid), .evReady(evReady),
    .evLine(evLine), .flushReq(flushReq), .reqValid(reqValid), .reqReady(reqReady),
    .reqWriteBack(reqWriteBack), .reqAddr(reqAddr), .reqMask(reqMask), .reqSize(reqSize)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [5:0]  size;
    logic        crit;
    logic        through;
    logic [7:0]  mask;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0100, 6'd4,  1'b0, 1'b0, 8'h01},
    '{32'h0000_0128, 6'd8,  1'b0, 1'b0, 8'h0C},
    '{32'h0000_0140, 6'd32, 1'b0, 1'b0, 8'hFF},
    '{32'h0000_0208, 6'd16, 1'b0, 1'b0, 8'h3C},
    '{32'h0000_0301, 6'd1,  1'b0, 1'b1, 8'h00},
    '{32'h0000_0302, 6'd2,  1'b0, 1'b1, 8'h00},
    '{32'h0000_0304, 6'd3,  1'b0, 1'b1, 8'h00},
    '{32'h0000_0310, 6'd4,  1'b1, 1'b1, 8'h00},
    '{32'h0000_031C, 6'd8,  1'b0, 1'b1, 8'h00},
    '{32'h0000_0306, 6'd4,  1'b0, 1'b1, 8'h00},
    '{32'h0000_033C, 6'd4,  1'b0, 1'b0, 8'h80},
    '{32'h0000_0344, 6'd12, 1'b0, 1'b0, 8'h0E}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic store(input logic [31:0] a, input logic [5:0] s, input logic c);
    @(negedge clk);
    stValid = 1'b1; stAddr = a; stSize = s; stCrit = c;
    @(negedge clk);
    stValid = 1'b0; stCrit = 1'b0;
  endtask

  task automatic evict(input logic [31:0] a);
    @(negedge clk);
    evValid = 1'b1; evLine = a[31:5];
    @(negedge clk);
    evValid = 1'b0;
  endtask

  task automatic storeEvict(input logic [31:0] a, input logic [5:0] s, input logic [31:0] ea);
    @(negedge clk);
    stValid = 1'b1; stAddr = a; stSize = s; stCrit = 1'b0;
    evValid = 1'b1; evLine = ea[31:5];
    @(negedge clk);
    stValid = 1'b0; evValid = 1'b0;
  endtask

  // at a falling edge: check pending request, then take it
  task automatic expectReq(input bit wb, input logic [31:0] a, input logic [7:0] v, input string tag);
    chk(reqValid === 1'b1, {tag, " valid"}, 32'(reqValid), 32'd1);
    chk(reqWriteBack === wb, {tag, " kind"}, 32'(reqWriteBack), 32'(wb));
    chk(reqAddr === a, {tag, " addr"}, reqAddr, a);
    if (wb) chk(reqMask === v, {tag, " mask"}, 32'(reqMask), 32'(v));
    else    chk(reqSize === v[5:0], {tag, " size"}, 32'(reqSize), 32'(v[5:0]));
    reqReady = 1'b1;
    @(negedge clk);
    reqReady = 1'b0;
  endtask

  task automatic expectNone(input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (reqValid !== 1'b0) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, {tag, " no request"}, 32'(seen), 32'd0);
  endtask

  task automatic waitReq();
    for (int i = 0; i < 12 && reqValid !== 1'b1; i++) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    chk(reqValid === 1'b0, "R11 reqValid", 32'(reqValid), 32'd0);
    chk(stReady === 1'b1, "R11 stReady", 32'(stReady), 32'd1);
    chk(evReady === 1'b1, "R11 evReady", 32'(evReady), 32'd1);

    // table: classification (R1..R5) and eviction write-back (R6)
    for (int i = 0; i < NVEC; i++) begin
      store(VECS[i].addr, VECS[i].size, VECS[i].crit);
      if (VECS[i].through) begin
        expectReq(1'b0, VECS[i].addr, {2'b0, VECS[i].size},
                  VECS[i].crit ? "R3 crit" : (VECS[i].size < 4 ? "R2 subword" : "R4 misfit"));
        evict(VECS[i].addr);
        expectNone("R3/R4 no mask bits");
      end else begin
        chk(reqValid === 1'b0, "R1 tracked quiet", 32'(reqValid), 32'd0);
        evict(VECS[i].addr);
        expectReq(1'b1, VECS[i].addr & 32'hFFFF_FFE0, VECS[i].mask, "R5 R6 mask");
      end
    end

    // R5 accumulation
    store(32'h0000_0600, 6'd4, 1'b0);
    store(32'h0000_0618, 6'd8, 1'b0);
    store(32'h0000_0604, 6'd4, 1'b0);
    evict(32'h0000_0600);
    expectReq(1'b1, 32'h0000_0600, 8'hC3, "R5 accumulate");
    // R6 eviction of an untracked line
    evict(32'h0000_0700);
    expectNone("R6 no entry");

    // R9 stall and hold
    store(32'h0000_0401, 6'd1, 1'b0);
    chk(stReady === 1'b0, "R9 stReady low", 32'(stReady), 32'd0);
    chk(evReady === 1'b0, "R9 evReady low", 32'(evReady), 32'd0);
    @(negedge clk);
    @(negedge clk);
    expectReq(1'b0, 32'h0000_0401, 8'd1, "R9 held");

    // R7 LRU replacement in set 0
    for (int k = 0; k < 4; k++) store(32'h0000_0800 + 32'(k * 64) + 32'(k * 4), 6'd4, 1'b0);
    store(32'h0000_081C, 6'd4, 1'b0);
    chk(reqValid === 1'b0, "R7 fill quiet", 32'(reqValid), 32'd0);
    store(32'h0000_0900, 6'd4, 1'b0);
    expectReq(1'b1, 32'h0000_0840, 8'h02, "R7 LRU victim");

    // R8 flush order: set 0 ways 0..3
    @(negedge clk);
    flushReq = 1'b1;
    @(negedge clk);
    flushReq = 1'b0;
    chk(stReady === 1'b0, "R8 stall during scan", 32'(stReady), 32'd0);
    waitReq(); expectReq(1'b1, 32'h0000_0800, 8'h81, "R8 flush way0");
    waitReq(); expectReq(1'b1, 32'h0000_0900, 8'h01, "R8 flush way1");
    waitReq(); expectReq(1'b1, 32'h0000_0880, 8'h04, "R8 flush way2");
    waitReq(); expectReq(1'b1, 32'h0000_08C0, 8'h08, "R8 flush way3");
    expectNone("R8 flush end");
    evict(32'h0000_0800);
    expectNone("R8 entry cleared");

    // R10 same-cycle store and eviction
    store(32'h0000_1008, 6'd4, 1'b0);
    storeEvict(32'h0000_1014, 6'd4, 32'h0000_1000);
    expectReq(1'b1, 32'h0000_1000, 8'h24, "R10 hit merge");
    evict(32'h0000_1000);
    expectNone("R10 entry gone");
    storeEvict(32'h0000_2020, 6'd4, 32'h0000_2020);
    expectReq(1'b1, 32'h0000_2020, 8'h01, "R10 miss merge");
    evict(32'h0000_2020);
    expectNone("R10 no alloc");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule